// File: doc/BRIEF.md
# Skewed Matrix Bank Mapper

This block generates addresses for a 16x16 matrix stored across 17 memory banks with a skewed placement. Because the bank count is prime, every full row, every full column, the main diagonal and the anti-diagonal land in 16 different banks. Any of these lines can therefore be fetched in a single memory cycle without a bank conflict. Element (r,c) lives in bank (4*r + c) mod 17, at word r of that bank. Element (0,0) sits in bank 0.

A request names an access mode and a line index. The block answers in two forms. The parallel path returns, one cycle later, the bank number and in-bank word address of all 16 elements as one packed vector, together with a conflict flag from a pairwise bank comparator. The serial path walks the same 16 elements one per cycle, for a consumer that issues one access at a time. The bank arrays and the data crossbar sit outside this block.

Top module: `skew_bank_mapper`

## Requirements
- R1: In the cycle after a clock edge that samples req_valid high, vec_valid is high and the vectors describe that request. In the cycle after an edge that samples req_valid low, vec_valid is low.
- R2: Row mode (req_mode = 0) selects element k = (index, k). Its bank is (4*index + k) mod 17 and its word address is index.
- R3: Column mode (req_mode = 1) selects element k = (k, index). Its bank is (4*k + index) mod 17 and its word address is k.
- R4: Diagonal mode (req_mode = 2) selects element k = (k, k). Its bank is 5*k mod 17 and its word address is k. req_index has no effect in this mode.
- R5: Anti-diagonal mode (req_mode = 3) selects element k = (k, 15-k). Its bank is (3*k + 15) mod 17 and its word address is k. req_index has no effect in this mode.
- R6: vec_conflict is high together with vec_valid only when two entries of the vector share a bank. For every mode and index all 16 banks are distinct, so the flag stays low.
- R7: Element k occupies bits [5k+4:5k] of vec_bank and bits [4k+3:4k] of vec_addr.
- R8: A request sampled while no walk is running starts a walk. For the next 16 cycles ser_valid is high, ser_elem counts 0 to 15, and ser_bank and ser_addr follow the same mapping as the parallel path.
- R9: ser_last is high only while element 15 is shown. After that element ser_valid falls, unless a request was sampled during that last cycle. In that case the next walk starts with no gap.
- R10: A request sampled during a walk, before its last element, does not change the walk in progress. It is not queued.
- R11: After a synchronous active-low reset, vec_valid, vec_conflict, ser_valid and ser_last are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 2 | 0 row, 1 column, 2 diagonal, 3 anti-diagonal |
| req_index | input | 4 | Row or column number for modes 0 and 1 |
| vec_valid | output | 1 | Parallel vector valid |
| vec_bank | output | 80 | 16 bank numbers, 5 bits each, element 0 lowest |
| vec_addr | output | 64 | 16 in-bank word addresses, 4 bits each |
| vec_conflict | output | 1 | Two vector entries share a bank |
| ser_valid | output | 1 | Serial walk element valid |
| ser_elem | output | 4 | Element number within the walk |
| ser_bank | output | 5 | Bank of the current element |
| ser_addr | output | 4 | Word address of the current element |
| ser_last | output | 1 | Current element is the last of the walk |

## Verification
The parallel path is first compared against a short table of hand-worked lines. This table includes row 15 and column 7, where the sum 4*r + c wraps past 17 more than once, which separates a correct modulo from a truncation. It also includes the anti-diagonal start (0,15), which separates the column order of the anti-diagonal from that of the main diagonal. Every mode and every index is then swept. Each entry is compared with the coordinate formula and tested for distinct banks, and the diagonal modes are swept under different index values to show that the index is ignored. Serial walks are checked element by element, with an intruding request in the middle and a back-to-back request on the last element. These two cases separate dropping a request, restarting a walk and chaining a walk.

// File: rtl/skew_pkg.sv
// Shared types for the skewed matrix bank mapper.
package skew_pkg;
    // Line access modes; the encoding is visible on the req_mode port.
    typedef enum logic [1:0] {
        MODE_ROW  = 2'd0,
        MODE_COL  = 2'd1,
        MODE_DIAG = 2'd2,
        MODE_ANTI = 2'd3
    } line_mode_e;
endpackage

// File: rtl/skew_coord.sv
// Maps (mode, line index, element number) to a matrix coordinate.
// Assumes a square matrix of N = 2^(2P) rows; index is ignored for diagonals.
module skew_coord
    import skew_pkg::*;
#(
    parameter int P = 2,
    localparam int IDX_W = 2 * P
) (
    input  line_mode_e       mode,
    input  logic [IDX_W-1:0] index,
    input  logic [IDX_W-1:0] elem,
    output logic [IDX_W-1:0] row,
    output logic [IDX_W-1:0] col
);
    localparam logic [IDX_W-1:0] LAST = '1;

    // Select the coordinate of element elem on the requested line.
    always_comb begin
        unique case (mode)
            MODE_ROW:  begin row = index; col = elem;        end
            MODE_COL:  begin row = elem;  col = index;       end
            MODE_DIAG: begin row = elem;  col = elem;        end
            default:   begin row = elem;  col = LAST - elem; end
        endcase
    end
endmodule

// File: rtl/skew_bank_map.sv
// Skewed placement: bank = (2^P * row + col) mod (2^(2P)+1), word = row.
// Assumes the prime-count bank layout; purely combinational.
module skew_bank_map #(
    parameter int P = 2,
    localparam int IDX_W  = 2 * P,
    localparam int BANKS  = (1 << IDX_W) + 1,
    localparam int BANK_W = $clog2(BANKS),
    localparam int SUM_W  = IDX_W + P + 1
) (
    input  logic [IDX_W-1:0]  row,
    input  logic [IDX_W-1:0]  col,
    output logic [BANK_W-1:0] bank,
    output logic [IDX_W-1:0]  addr
);
    logic [SUM_W-1:0] lin;
    logic [SUM_W-1:0] rem;

    // Linear skewed position and its residue modulo the bank count.
    always_comb begin
        lin  = (SUM_W'(row) << P) + SUM_W'(col);
        rem  = lin % SUM_W'(BANKS);
        bank = rem[BANK_W-1:0];
        addr = row;
    end
endmodule

// File: rtl/skew_conflict_chk.sv
// Pairwise comparator: flags any two entries of a bank vector that match.
// Assumes NUM entries of W bits each, packed with entry 0 in the low bits.
module skew_conflict_chk #(
    parameter int NUM = 16,
    parameter int W   = 5
) (
    input  logic [NUM*W-1:0] banks,
    output logic             conflict
);
    // Compare every unordered pair of entries.
    always_comb begin
        conflict = 1'b0;
        for (int i = 0; i < NUM; i++) begin
            for (int j = i + 1; j < NUM; j++) begin
                if (banks[i*W +: W] == banks[j*W +: W]) conflict = 1'b1;
            end
        end
    end
endmodule

// File: rtl/skew_walker.sv
// Serial walker: presents one line element per cycle for 2^(2P) cycles.
// Assumes requests during a walk are dropped except on the last element.
module skew_walker
    import skew_pkg::*;
#(
    parameter int P = 2,
    localparam int IDX_W  = 2 * P,
    localparam int BANKS  = (1 << IDX_W) + 1,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  line_mode_e        req_mode,
    input  logic [IDX_W-1:0]  req_index,
    output logic              ser_valid,
    output logic [IDX_W-1:0]  ser_elem,
    output logic [BANK_W-1:0] ser_bank,
    output logic [IDX_W-1:0]  ser_addr,
    output logic              ser_last
);
    localparam logic [IDX_W-1:0] LAST = '1;

    logic             busy_q;
    logic [IDX_W-1:0] cnt_q;
    line_mode_e       mode_q;
    logic [IDX_W-1:0] index_q;
    logic [IDX_W-1:0] row;
    logic [IDX_W-1:0] col;
    logic             at_last;
    logic             accept;

    assign at_last = busy_q && (cnt_q == LAST);
    assign accept  = req_valid && (!busy_q || at_last);

    // Walk state: start on accepted request, step, stop after the last element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            mode_q  <= MODE_ROW;
            index_q <= '0;
        end else if (accept) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            mode_q  <= req_mode;
            index_q <= req_index;
        end else if (busy_q) begin
            busy_q <= !at_last;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    skew_coord #(.P(P)) u_coord (
        .mode(mode_q), .index(index_q), .elem(cnt_q), .row(row), .col(col)
    );

    skew_bank_map #(.P(P)) u_map (
        .row(row), .col(col), .bank(ser_bank), .addr(ser_addr)
    );

    assign ser_valid = busy_q;
    assign ser_elem  = cnt_q;
    assign ser_last  = at_last;

    // R8: a running walk advances by one element per cycle.
    p_walk_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && !ser_last) |=> (ser_valid && ser_elem == $past(ser_elem) + 1'b1));
    // R9: after the last element the walk ends unless a request chains.
    p_walk_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_last && !req_valid) |=> !ser_valid);
    // R9: a request on the last element starts a fresh walk at element 0.
    p_walk_chain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_last && req_valid) |=> (ser_valid && ser_elem == '0));
    // R10: mid-walk requests leave the latched line unchanged.
    p_walk_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !at_last) |=> ($stable(mode_q) && $stable(index_q)));
endmodule

// File: rtl/skew_bank_mapper.sv
// Top: parallel and serial address generation for a skewed matrix memory.
// Assumes 2^(2P) x 2^(2P) matrix in 2^(2P)+1 banks; one request per cycle.
module skew_bank_mapper
    import skew_pkg::*;
#(
    parameter int P = 2,
    localparam int N      = 1 << (2 * P),
    localparam int IDX_W  = 2 * P,
    localparam int BANKS  = N + 1,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_mode,
    input  logic [IDX_W-1:0]    req_index,
    output logic                vec_valid,
    output logic [N*BANK_W-1:0] vec_bank,
    output logic [N*IDX_W-1:0]  vec_addr,
    output logic                vec_conflict,
    output logic                ser_valid,
    output logic [IDX_W-1:0]    ser_elem,
    output logic [BANK_W-1:0]   ser_bank,
    output logic [IDX_W-1:0]    ser_addr,
    output logic                ser_last
);
    line_mode_e          mode;
    logic [N*BANK_W-1:0] bank_comb;
    logic [N*IDX_W-1:0]  addr_comb;
    logic                conflict_comb;

    assign mode = line_mode_e'(req_mode);

    // One coordinate and bank lane per element of the line.
    for (genvar k = 0; k < N; k++) begin : g_lane
        logic [IDX_W-1:0] row;
        logic [IDX_W-1:0] col;
        skew_coord #(.P(P)) u_coord (
            .mode(mode), .index(req_index), .elem(IDX_W'(k)),
            .row(row), .col(col)
        );
        skew_bank_map #(.P(P)) u_map (
            .row(row), .col(col),
            .bank(bank_comb[k*BANK_W +: BANK_W]),
            .addr(addr_comb[k*IDX_W +: IDX_W])
        );
    end

    skew_conflict_chk #(.NUM(N), .W(BANK_W)) u_chk (
        .banks(bank_comb), .conflict(conflict_comb)
    );

    // Register the full vector one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid    <= 1'b0;
            vec_conflict <= 1'b0;
            vec_bank     <= '0;
            vec_addr     <= '0;
        end else begin
            vec_valid    <= req_valid;
            vec_conflict <= req_valid && conflict_comb;
            if (req_valid) begin
                vec_bank <= bank_comb;
                vec_addr <= addr_comb;
            end
        end
    end

    skew_walker #(.P(P)) u_walk (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(mode),
        .req_index(req_index), .ser_valid(ser_valid), .ser_elem(ser_elem),
        .ser_bank(ser_bank), .ser_addr(ser_addr), .ser_last(ser_last)
    );

    // R1: every sampled request yields a valid vector next cycle.
    p_vec_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> vec_valid);
    // R1: no request, no vector.
    p_vec_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !vec_valid);
    // R6: skewed lines never collide in a bank.
    p_no_conflict_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !vec_conflict);
    // R9: the last-element marker only appears on a valid element.
    p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ser_last |-> ser_valid);
endmodule

// File: tb/skew_bank_mapper_tb.sv
module skew_bank_mapper_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = 2'd0;
    logic [3:0]  req_index = 4'd0;
    logic        vec_valid;
    logic [79:0] vec_bank;
    logic [63:0] vec_addr;
    logic        vec_conflict;
    logic        ser_valid;
    logic [3:0]  ser_elem;
    logic [4:0]  ser_bank;
    logic [3:0]  ser_addr;
    logic        ser_last;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    skew_bank_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_index(req_index), .vec_valid(vec_valid), .vec_bank(vec_bank),
        .vec_addr(vec_addr), .vec_conflict(vec_conflict), .ser_valid(ser_valid),
        .ser_elem(ser_elem), .ser_bank(ser_bank), .ser_addr(ser_addr),
        .ser_last(ser_last)
    );

    // mode, index, bank of element 0, bank of element 15, addr 0, addr 15
    localparam int NT = 7;
    localparam int TBL [NT][6] = '{
        '{0,  0,  0,  15, 0,  0},
        '{0, 15,  9,   7, 15, 15},
        '{0,  3, 12,  10, 3,  3},
        '{1,  0,  0,   9, 0,  15},
        '{1,  7,  7,  16, 0,  15},
        '{2,  0,  0,   7, 0,  15},
        '{3,  0, 15,   9, 0,  15}
    };

    function automatic int exp_row(int m, int idx, int k);
        return (m == 0) ? idx : k;
    endfunction
    function automatic int exp_col(int m, int idx, int k);
        case (m)
            0: return k;
            1: return idx;
            2: return k;
            default: return 15 - k;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string mreq(int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Issue one parallel request; returns after the vector is registered.
    task automatic par_req(int m, int idx);
        @(negedge clk);
        req_valid = 1'b1; req_mode = 2'(m); req_index = 4'(idx);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_vector(int m, int idx);
        int seen = 0;
        check("R1", int'(vec_valid), 1);
        check("R6", int'(vec_conflict), 0);
        for (int k = 0; k < 16; k++) begin
            int r = exp_row(m, idx, k);
            int c = exp_col(m, idx, k);
            int b = int'(vec_bank[k*5 +: 5]);
            check(mreq(m), b, (4*r + c) % 17);
            check("R7", int'(vec_addr[k*4 +: 4]), r);
            if (b < 17) begin
                check("R6", (seen >> b) & 1, 0);
                seen = seen | (1 << b);
            end
        end
    endtask

    task automatic wait_idle();
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11", int'(vec_valid), 0);
        check("R11", int'(vec_conflict), 0);
        check("R11", int'(ser_valid), 0);
        check("R11", int'(ser_last), 0);
        rst_n = 1'b1;

        // Table of hand-worked lines
        for (int t = 0; t < NT; t++) begin
            par_req(TBL[t][0], TBL[t][1]);
            check(mreq(TBL[t][0]), int'(vec_bank[4:0]), TBL[t][2]);
            check(mreq(TBL[t][0]), int'(vec_bank[79:75]), TBL[t][3]);
            check("R7", int'(vec_addr[3:0]), TBL[t][4]);
            check("R7", int'(vec_addr[63:60]), TBL[t][5]);
        end

        // R1: vector drops with no request
        @(negedge clk);
        check("R1", int'(vec_valid), 0);

        // Exhaustive sweep; index varied also for diagonals (R4, R5 ignore it)
        for (int m = 0; m < 4; m++) begin
            for (int idx = 0; idx < 16; idx++) begin
                par_req(m, idx);
                check_vector(m, idx);
            end
        end

        // R8/R10: serial walk with an intruding mid-walk request
        wait_idle();
        check("R8", int'(ser_valid), 0);
        @(negedge clk);
        req_valid = 1'b1; req_mode = 2'd1; req_index = 4'd6;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 16; k++) begin
            check("R8", int'(ser_valid), 1);
            check("R8", int'(ser_elem), k);
            check("R10", int'(ser_bank), (4*k + 6) % 17);
            check("R10", int'(ser_addr), k);
            check("R9", int'(ser_last), (k == 15) ? 1 : 0);
            if (k == 5) begin
                req_valid = 1'b1; req_mode = 2'd3; req_index = 4'd2;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        check("R9", int'(ser_valid), 0);
        check("R9", int'(ser_last), 0);

        // R9: back-to-back walk chained on the last element
        wait_idle();
        @(negedge clk);
        req_valid = 1'b1; req_mode = 2'd2; req_index = 4'd9;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 16; k++) begin
            check("R4", int'(ser_bank), (5*k) % 17);
            if (k == 15) begin
                req_valid = 1'b1; req_mode = 2'd0; req_index = 4'd15;
            end
            @(negedge clk);
            req_valid = 1'b0;
        end
        check("R9", int'(ser_valid), 1);
        check("R9", int'(ser_elem), 0);
        check("R2", int'(ser_bank), 9);
        check("R2", int'(ser_addr), 15);

        // R11: reset mid-walk clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", int'(ser_valid), 0);
        check("R11", int'(vec_valid), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule